// File: doc/BRIEF.md
# Phase-Accumulator Voice Oscillator

This block is the oscillator of one synthesizer voice. A 24-bit phase register steps forward by a 16-bit frequency word on every sample tick and wraps freely at 2^24. The output is a 12-bit sample built from the top twelve phase bits in one of four shapes: a rising ramp, a folded triangle, a rectangular pulse whose duty is set by a 12-bit width word, and pseudo-random noise from a 23-bit linear feedback shift register.

The block runs from a fast system clock. A one-cycle `tick` strobe at the audio rate, typically 1 MHz, moves it forward. Between strobes all state holds. With a frequency word of 1 a full phase cycle takes 2^24 ticks, about 16 s at 1 MHz. With the word at its maximum the tone is close to 4 kHz. A voice-enable input silences the output without stopping the phase, so re-enabling a voice keeps it in phase.

Top module: `voice_osc`

## Requirements
- R1: A synchronous active-low reset sets the phase to zero, the output sample to zero and the noise register to 23'h7FFFF8.
- R2: On each clock edge with `tick` high, the phase becomes (phase + `freq`) modulo 2^24.
- R3: On clock edges with `tick` low, the phase, the noise register and `sample` keep their values.
- R4: With `wsel` = 1 (ramp), the sample is phase bits 23:12.
- R5: With `wsel` = 0 (triangle), the sample is {phase[22:12], 1'b0}, with all 12 bits inverted when phase bit 23 is 1.
- R6: With `wsel` = 2 (pulse), the sample is 12'hFFF when phase bits 23:12 are below `pw`, and 12'h000 otherwise. A `pw` of zero gives a constant zero.
- R7: With `wsel` = 3 (noise), the sample is {n[20], n[18], n[14], n[11], n[9], n[5], n[2], n[0], 4'b0000}, where n is the noise register. On a tick where phase bit 19 goes from 0 to 1, n shifts left by one and takes n[22] XOR n[17] into bit 0.
- R8: On a tick with `voice_en` low, the sample becomes zero. The phase and the noise register still advance.
- R9: The sample written on a tick is computed from the phase and noise values held just before that tick's update, so the sample lags the phase by one tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Sample-rate advance strobe, one clock wide |
| freq | input | 16 | Phase increment per tick |
| pw | input | 12 | Pulse width compare word |
| wsel | input | 2 | Waveform select: 0 triangle, 1 ramp, 2 pulse, 3 noise |
| voice_en | input | 1 | Output enable; zero forces a silent sample |
| sample | output | 12 | Registered waveform sample |

## Verification
The clocked assertions assume that `tick` is a clean level, sampled only at clock edges, and that `freq`, `pw`, `wsel` and `voice_en` are stable around each edge. The bench drives every input on the falling edge, which meets this. The noise assertions assume that reset loads a nonzero seed and that the register moves only on a phase bit 19 rise. The bench checks the noise sequence over hundreds of ticks with increments that cross bit 19 often. The stimulus puts idle cycles between ticks so that the hold properties are exercised. It also resets in the middle of a run with `tick` held high, so the reset is seen to win over the strobe.

// File: rtl/voice_pkg.sv
`timescale 1ns/1ps
// voice_pkg: shared widths and waveform codes for the voice oscillator.
// Assumes the select encoding below is fixed by the register map upstream.
package voice_pkg;
    localparam int PHASE_W = 24;
    localparam int STEP_W  = 16;
    localparam int SAMP_W  = 12;
    localparam int NOISE_W = 23;

    typedef enum logic [1:0] {
        WAVE_TRI   = 2'd0,
        WAVE_RAMP  = 2'd1,
        WAVE_PULSE = 2'd2,
        WAVE_NOISE = 2'd3
    } wave_sel_e;
endpackage

// File: rtl/phase_accum.sv
`timescale 1ns/1ps
// phase_accum: free-running phase register advanced by a step word per tick.
// Exposes the top OUT_W phase bits and a strobe for a 0->1 edge of MARK_BIT.
// Assumes STEP_W < PHASE_W and tick is one clock wide per sample period.
module phase_accum #(
    parameter int PHASE_W  = 24,
    parameter int STEP_W   = 16,
    parameter int OUT_W    = 12,
    parameter int MARK_BIT = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [STEP_W-1:0] step,
    output logic [OUT_W-1:0]  phase_hi,
    output logic              mark_rise
);
    localparam int PAD_W = PHASE_W - STEP_W;

    logic [PHASE_W-1:0] phase_q;
    logic [PHASE_W-1:0] phase_nxt;

    // Next phase: modular add of the zero-extended step.
    always_comb begin
        phase_nxt = phase_q + {{PAD_W{1'b0}}, step};
    end

    // Phase register: cleared on reset, advanced only on tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (tick)
            phase_q <= phase_nxt;
    end

    assign phase_hi  = phase_q[PHASE_W-1 -: OUT_W];
    assign mark_rise = tick && !phase_q[MARK_BIT] && phase_nxt[MARK_BIT];

    // Phase moves by exactly the step on a tick.
    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> phase_q == $past(phase_q) + {{PAD_W{1'b0}}, $past(step)});

    // Phase holds between ticks.
    assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(phase_q));
endmodule

// File: rtl/noise_lfsr.sv
`timescale 1ns/1ps
// noise_lfsr: Fibonacci shift register producing the noise byte.
// Shifts left on 'shift' with feedback TAP_A ^ TAP_B into bit 0.
// Assumes W >= 21 so all picked bit positions exist; SEED must be nonzero.
module noise_lfsr #(
    parameter int           W     = 23,
    parameter int           TAP_A = 22,
    parameter int           TAP_B = 17,
    parameter logic [W-1:0] SEED  = 23'h7FFFF8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       shift,
    output logic [7:0] noise_byte
);
    localparam int PICK_N = 8;
    localparam int PICK [PICK_N] = '{20, 18, 14, 11, 9, 5, 2, 0};

    logic [W-1:0] state_q;

    // Shift register: seeded on reset, advanced on a shift strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SEED;
        else if (shift)
            state_q <= {state_q[W-2:0], state_q[TAP_A] ^ state_q[TAP_B]};
    end

    // Scatter-pick eight state bits, first pick landing in the MSB.
    for (genvar g = 0; g < PICK_N; g++) begin : g_pick
        assign noise_byte[PICK_N-1-g] = state_q[PICK[g]];
    end

    // Register never reaches the all-zero lock-up state.
    assert_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);

    // Register holds unless told to shift.
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !shift |=> $stable(state_q));
endmodule

// File: rtl/wave_shaper.sv
`timescale 1ns/1ps
// wave_shaper: combinational waveform select from the top phase bits.
// Assumes OUT_W >= 8 (noise fills the top byte, the rest is zero padding).
module wave_shaper
    import voice_pkg::*;
#(
    parameter int OUT_W = 12
) (
    input  logic [OUT_W-1:0] phase_hi,
    input  logic [OUT_W-1:0] width,
    input  logic [7:0]       noise_byte,
    input  wave_sel_e        sel,
    input  logic             en,
    output logic [OUT_W-1:0] wave
);
    localparam int PAD_W = OUT_W - 8;

    logic [OUT_W-1:0] tri_w;
    logic [OUT_W-1:0] pulse_w;
    logic [OUT_W-1:0] noise_w;

    // Triangle: doubled ramp, folded by the phase MSB.
    always_comb begin
        tri_w = {phase_hi[OUT_W-2:0], 1'b0} ^ {OUT_W{phase_hi[OUT_W-1]}};
    end

    // Pulse: full scale while phase is below the width word.
    always_comb begin
        pulse_w = (phase_hi < width) ? '1 : '0;
    end

    // Noise: picked byte in the MSBs, zero below.
    always_comb begin
        noise_w = {noise_byte, {PAD_W{1'b0}}};
    end

    // Output select with voice mute.
    always_comb begin
        if (!en) begin
            wave = '0;
        end else begin
            unique case (sel)
                WAVE_TRI:   wave = tri_w;
                WAVE_RAMP:  wave = phase_hi;
                WAVE_PULSE: wave = pulse_w;
                WAVE_NOISE: wave = noise_w;
                default:    wave = '0;
            endcase
        end
    end

    // Pulse output is only ever full scale or zero.
    always_comb begin
        if (en && sel == WAVE_PULSE)
            assert_pulse_level_R6: assert (wave == '0 || wave == '1);
    end

    // Noise low padding stays zero.
    always_comb begin
        if (en && sel == WAVE_NOISE)
            assert_noise_pad_R7: assert (wave[PAD_W-1:0] == '0);
    end
endmodule

// File: rtl/voice_osc.sv
`timescale 1ns/1ps
// voice_osc: one voice oscillator. Phase accumulator, noise register and
// waveform shaper, with the selected sample registered on each tick.
// Assumes inputs are synchronous to clk and tick is a one-cycle strobe.
module voice_osc
    import voice_pkg::*;
#(
    parameter int PHASE_W  = voice_pkg::PHASE_W,
    parameter int STEP_W   = voice_pkg::STEP_W,
    parameter int SAMP_W   = voice_pkg::SAMP_W,
    parameter int NOISE_W  = voice_pkg::NOISE_W,
    parameter int MARK_BIT = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [STEP_W-1:0] freq,
    input  logic [SAMP_W-1:0] pw,
    input  logic [1:0]        wsel,
    input  logic              voice_en,
    output logic [SAMP_W-1:0] sample
);
    logic [SAMP_W-1:0] phase_hi;
    logic              mark_rise;
    logic [7:0]        noise_byte;
    logic [SAMP_W-1:0] wave;
    logic [SAMP_W-1:0] sample_q;

    phase_accum #(
        .PHASE_W (PHASE_W),
        .STEP_W  (STEP_W),
        .OUT_W   (SAMP_W),
        .MARK_BIT(MARK_BIT)
    ) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .step     (freq),
        .phase_hi (phase_hi),
        .mark_rise(mark_rise)
    );

    noise_lfsr #(
        .W    (NOISE_W),
        .TAP_A(22),
        .TAP_B(17),
        .SEED (NOISE_W'(23'h7FFFF8))
    ) u_noise (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift     (mark_rise),
        .noise_byte(noise_byte)
    );

    wave_shaper #(
        .OUT_W(SAMP_W)
    ) u_shape (
        .phase_hi  (phase_hi),
        .width     (pw),
        .noise_byte(noise_byte),
        .sel       (wave_sel_e'(wsel)),
        .en        (voice_en),
        .wave      (wave)
    );

    // Output sample register: captures the pre-update wave on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sample_q <= '0;
        else if (tick)
            sample_q <= wave;
    end

    assign sample = sample_q;

    // A muted tick yields a silent sample.
    assert_mute_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !voice_en) |=> sample == '0);

    // Sample holds between ticks.
    assert_sample_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(sample));
endmodule

// File: tb/voice_osc_test.sv
`timescale 1ns/1ps
module voice_osc_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [15:0] freq = '0;
    logic [11:0] pw = '0;
    logic [1:0]  wsel = '0;
    logic        voice_en = 1'b0;
    logic [11:0] sample;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [23:0] m_acc;
    logic [22:0] m_lfsr;

    always #5 clk = ~clk;

    voice_osc uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .freq    (freq),
        .pw      (pw),
        .wsel    (wsel),
        .voice_en(voice_en),
        .sample  (sample)
    );

    typedef struct packed {
        logic [15:0] f;
        logic [11:0] w;
        logic [1:0]  s;
        logic        e;
        logic [9:0]  n;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{16'h1234, 12'h800, 2'd1, 1'b1, 10'd300},
        '{16'hFFFF, 12'h800, 2'd0, 1'b1, 10'd300},
        '{16'h4000, 12'h400, 2'd2, 1'b1, 10'd300},
        '{16'hF123, 12'h000, 2'd3, 1'b1, 10'd400},
        '{16'h0800, 12'h000, 2'd2, 1'b1, 10'd100},
        '{16'hABCD, 12'hFFF, 2'd2, 1'b1, 10'd300},
        '{16'h7777, 12'h800, 2'd3, 1'b0, 10'd100},
        '{16'h8000, 12'h123, 2'd0, 1'b1, 10'd300}
    };

    function automatic logic [11:0] model_wave(input logic [23:0] a, input logic [22:0] l,
                                               input logic [11:0] w, input logic [1:0] s,
                                               input logic e);
        logic [11:0] ph;
        ph = a[23:12];
        if (!e) return 12'h000;
        case (s)
            2'd0: return {ph[10:0], 1'b0} ^ {12{ph[11]}};
            2'd1: return ph;
            2'd2: return (ph < w) ? 12'hFFF : 12'h000;
            default: return {l[20], l[18], l[14], l[11], l[9], l[5], l[2], l[0], 4'b0000};
        endcase
    endfunction

    function automatic string tag_of(input logic [1:0] s, input logic e);
        if (!e) return "R8";
        case (s)
            2'd0: return "R5";
            2'd1: return "R4";
            2'd2: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: sample=%h expected=%h", tag, act, exp);
        end
    endtask

    // Model one tick: returns the sample expected after it (R9 lag).
    task automatic model_tick(output logic [11:0] exp);
        logic [23:0] nxt;
        exp = model_wave(m_acc, m_lfsr, pw, wsel, voice_en);
        nxt = m_acc + {8'd0, freq};
        if (!m_acc[19] && nxt[19])
            m_lfsr = {m_lfsr[21:0], m_lfsr[22] ^ m_lfsr[17]};
        m_acc = nxt;
    endtask

    // Called at a negedge; one tick, then check at the next negedge.
    task automatic one_tick(input string tag, input bit idle);
        logic [11:0] exp;
        tick = 1'b1;
        model_tick(exp);
        @(negedge clk);
        tick = 1'b0;
        chk(tag, sample, exp);
        if (idle) begin
            @(negedge clk);
            chk("R3", sample, exp);
        end
    endtask

    // Reset with tick held high; reset must win (R1).
    task automatic do_reset();
        rst_n = 1'b0;
        tick = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick = 1'b0;
        m_acc = '0;
        m_lfsr = 23'h7FFFF8;
        chk("R1", sample, 12'h000);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        do_reset();

        // R1: seeded noise register shows on the first noise tick.
        wsel = 2'd3; voice_en = 1'b1; freq = 16'h0001;
        one_tick("R1", 1'b0);
        chk("R1", sample, 12'hFC0);

        // Table walk: every tick checked, idle cycle every 5th tick.
        for (int v = 0; v < NVEC; v++) begin
            do_reset();
            freq = VECS[v].f; pw = VECS[v].w; wsel = VECS[v].s; voice_en = VECS[v].e;
            for (int k = 0; k < int'(VECS[v].n); k++)
                one_tick(tag_of(VECS[v].s, VECS[v].e), (k % 5) == 4);
        end

        // R2: step of 1 needs 4096 ticks to move the ramp by one LSB.
        do_reset();
        freq = 16'h0001; wsel = 2'd1; voice_en = 1'b1; pw = '0;
        tick = 1'b1;
        repeat (4097) @(negedge clk);
        tick = 1'b0;
        chk("R2", sample, 12'h001);

        // R2: maximum step wraps the phase; ramp after 257 ticks.
        do_reset();
        freq = 16'hFFFF; wsel = 2'd1;
        for (int k = 0; k < 258; k++) one_tick("R2", 1'b0);

        // R3: long idle with changing inputs leaves the sample alone.
        begin
            logic [11:0] held;
            held = sample;
            freq = 16'h3333; wsel = 2'd2; pw = 12'hFFF;
            repeat (20) @(negedge clk);
            chk("R3", sample, held);
            // R3: phase did not move during idle; resume ramp from model.
            wsel = 2'd1;
            one_tick("R3", 1'b0);
        end

        // R8 then unmute: phase kept running while muted (R9 lag).
        voice_en = 1'b0;
        for (int k = 0; k < 10; k++) one_tick("R8", 1'b0);
        voice_en = 1'b1;
        one_tick("R9", 1'b0);

        // R6 boundary: width FFF is ones except at phase FFF; width 0 is zero.
        do_reset();
        freq = 16'h0000; wsel = 2'd2; pw = 12'hFFF;
        one_tick("R6", 1'b0);
        chk("R6", sample, 12'hFFF);
        pw = 12'h000;
        one_tick("R6", 1'b0);
        chk("R6", sample, 12'h000);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: done=%0d expected=1", done);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule